// File: doc/BRIEF.md
# Receive Character Queue with Command Control

This block is a small first-in first-out store for received serial characters. It sits between a serial receive engine, which pushes one character with its status bits per write strobe, and a host read port that pops them in arrival order. Each entry is 11 bits wide, which is room for up to nine data bits plus status flags. The number of usable entries and the level that raises the threshold flag can both be set from one to four.

A command strobe carries a six-bit word. Any combination of its bits may be set in one write: turn reception on, turn it off, flush the receive engine, flush the queue, lock the queue and unlock it. The block resolves these with a fixed priority. Locking and unlocking only gate new writes and never move a pointer. The outputs are the fill level, full and empty flags, a threshold flag and a sticky overrun flag.

Top module: `rxq_top`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, thresh_hit is 0, overrun is 0, locked is 0, rx_enabled is 0, rx_flush_pulse is 0 and host_char is 0.
- R2: When reception is on, the queue is unlocked and it is not full, a rx_wr strobe stores rx_char. A host_rd on a non-empty queue pops the oldest entry, and the popped entry appears on host_char after that clock edge. Order is first in, first out.
- R3: A rx_wr strobe on a full queue with no pop in the same cycle is dropped and sets overrun. Overrun stays set until a queue flush. A pop and a write in the same cycle on a full queue both take effect.
- R4: A host_rd on an empty queue leaves host_char and level unchanged.
- R5: The usable depth is cfg_depth+1. The level equals writes minus reads, saturated at that depth, and full is 1 when the level equals the depth.
- R6: thresh_hit is 1 exactly when level is at least cfg_thresh+1.
- R7: While locked, rx_wr strobes are dropped and set overrun, and host reads still drain the stored entries.
- R8: Lock and unlock commands move neither pointer: entries stored before a lock/unlock pair are read back in order ahead of entries written after it.
- R9: cmd_word bit 2 (flush receive engine) clears the lock even when bit 4 (lock) is set in the same word, and it makes rx_flush_pulse 1 for exactly the cycle after the command.
- R10: cmd_word bit 3 (flush queue) empties the queue and clears overrun. A rx_wr or host_rd in the same cycle is discarded.
- R11: cmd_word bit 0 turns reception on and bit 1 turns it off, and off wins when both are set. A rx_wr while reception is off is dropped and does not set overrun.
- R12: cmd_word bit 5 (unlock) clears the lock, and it wins over bit 4 (lock) when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_wr | input | 1 | Write strobe from the receive engine |
| rx_char | input | 11 | Character and status bits to store |
| host_rd | input | 1 | Host read strobe |
| host_char | output | 11 | Last entry popped by the host |
| cmd_wr | input | 1 | Command strobe |
| cmd_word | input | 6 | Command bits: 0 on, 1 off, 2 flush engine, 3 flush queue, 4 lock, 5 unlock |
| cfg_depth | input | 2 | Usable depth minus one |
| cfg_thresh | input | 2 | Threshold level minus one |
| rx_enabled | output | 1 | Reception on |
| rx_flush_pulse | output | 1 | One-cycle flush request to the receive engine |
| locked | output | 1 | Queue locked against writes |
| level | output | 3 | Entries held, saturated at the depth |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| thresh_hit | output | 1 | Level at or above the threshold |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The hardest overlaps come from putting a queue flush in the same cycle as a receiver write or a host read, and putting a pop in the same cycle as a push on a full queue. The stimulus places these pairs on purpose, together with command words that set lock with flush-engine or with unlock. A behavioural model built on a queue predicts every output after each edge, and the outputs are compared on every cycle. A same-cycle conflict resolved with the wrong priority shows up as a wrong level, a wrong host_char or a wrong flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int CMD_W = 6;

   // bit order matches the cmd_word encoding
   typedef struct packed {
      logic unlock;
      logic lock;
      logic flush_q;
      logic flush_eng;
      logic rx_off;
      logic rx_on;
   } rxq_cmd_t;
endpackage

// File: rtl/rxq_cmd_ctl.sv
module rxq_cmd_ctl
   import rxq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cmd_wr,
   input  rxq_cmd_t cmd,
   output logic     rx_en,
   output logic     lock_q,
   output logic     eng_flush,
   output logic     q_flush
);
   logic do_lock, do_unlock;

   assign do_unlock = cmd_wr & (cmd.unlock | cmd.flush_eng);
   assign do_lock   = cmd_wr & cmd.lock & ~do_unlock;
   assign q_flush   = cmd_wr & cmd.flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en     <= 1'b0;
         lock_q    <= 1'b0;
         eng_flush <= 1'b0;
      end else begin
         eng_flush <= cmd_wr & cmd.flush_eng;
         if (cmd_wr && cmd.rx_off)
            rx_en <= 1'b0;
         else if (cmd_wr && cmd.rx_on)
            rx_en <= 1'b1;
         if (do_unlock)
            lock_q <= 1'b0;
         else if (do_lock)
            lock_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
   parameter int PTR_W = 2,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             rx_en,
   input  logic             lock_q,
   input  logic             q_flush,
   input  logic [PTR_W-1:0] depth_m1,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             push,
   output logic             pop,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             ovf_q
);
   logic [LVL_W-1:0] count;
   logic [LVL_W-1:0] depth_v;
   logic             ovf_set;

   function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] last);
      return (p == last) ? '0 : p + 1'b1;
   endfunction

   assign depth_v = LVL_W'(depth_m1) + 1'b1;
   assign full    = (count >= depth_v);
   assign empty   = (count == '0);
   assign level   = (count > depth_v) ? depth_v : count;

   assign pop     = rd_req & ~empty & ~q_flush;
   assign push    = wr_req & rx_en & ~lock_q & ~q_flush & (~full | pop);
   assign ovf_set = wr_req & rx_en & ~q_flush & (lock_q | (full & ~pop));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf_q  <= 1'b0;
      end else if (q_flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (push) wr_ptr <= step_ptr(wr_ptr, depth_m1);
         if (pop)  rd_ptr <= step_ptr(rd_ptr, depth_m1);
         count <= count + LVL_W'(push) - LVL_W'(pop);
         if (ovf_set) ovf_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int WIDTH     = 11,
   parameter int DEPTH_MAX = 4,
   parameter int PTR_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             pop,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] ent [DEPTH_MAX];

   for (genvar g = 0; g < DEPTH_MAX; g++) begin : g_ent
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
         if (push && wr_ptr == PTR_W'(g))
            q <= wr_data;
      end
      assign ent[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (pop)
         rd_data <= ent[rd_ptr];
   end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
   import rxq_pkg::*;
#(
   parameter int  WIDTH     = 11,
   parameter int  DEPTH_MAX = 4,
   parameter bit  THR_REG   = 1'b0,
   localparam int PTR_W     = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1,
   localparam int LVL_W     = $clog2(DEPTH_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_wr,
   input  logic [WIDTH-1:0] rx_char,
   input  logic             host_rd,
   output logic [WIDTH-1:0] host_char,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic [PTR_W-1:0] cfg_depth,
   input  logic [PTR_W-1:0] cfg_thresh,
   output logic             rx_enabled,
   output logic             rx_flush_pulse,
   output logic             locked,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             thresh_hit,
   output logic             overrun
);
   if (WIDTH < 10) begin : g_bad_width
      $error("rxq_top: WIDTH must hold nine data bits plus status");
   end
   if (DEPTH_MAX < 2) begin : g_bad_depth
      $error("rxq_top: DEPTH_MAX must be at least 2");
   end

   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH_MAX - 1);

   rxq_cmd_t         cmd;
   logic             q_flush, push, pop;
   logic [PTR_W-1:0] wr_ptr, rd_ptr, depth_m1, thr_m1;
   logic [LVL_W-1:0] thr_v;
   logic             thr_now;

   assign cmd      = rxq_cmd_t'(cmd_word);
   assign depth_m1 = (cfg_depth > LAST_IDX) ? LAST_IDX : cfg_depth;
   assign thr_m1   = (cfg_thresh > LAST_IDX) ? LAST_IDX : cfg_thresh;
   assign thr_v    = LVL_W'(thr_m1) + 1'b1;
   assign thr_now  = (level >= thr_v);

   rxq_cmd_ctl u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd       (cmd),
      .rx_en     (rx_enabled),
      .lock_q    (locked),
      .eng_flush (rx_flush_pulse),
      .q_flush   (q_flush)
   );

   rxq_ptrs #(.PTR_W(PTR_W), .LVL_W(LVL_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (rx_wr),
      .rd_req   (host_rd),
      .rx_en    (rx_enabled),
      .lock_q   (locked),
      .q_flush  (q_flush),
      .depth_m1 (depth_m1),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .push     (push),
      .pop      (pop),
      .level    (level),
      .full     (full),
      .empty    (empty),
      .ovf_q    (overrun)
   );

   rxq_store #(.WIDTH(WIDTH), .DEPTH_MAX(DEPTH_MAX), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wr_ptr  (wr_ptr),
      .wr_data (rx_char),
      .pop     (pop),
      .rd_ptr  (rd_ptr),
      .rd_data (host_char)
   );

   if (THR_REG) begin : g_thr_reg
      logic thr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) thr_q <= 1'b0;
         else        thr_q <= thr_now;
      end
      assign thresh_hit = thr_q;
   end else begin : g_thr_comb
      assign thresh_hit = thr_now;
   end
endmodule

// File: rtl/rxq_top_chk.sv
module rxq_top_chk #(
   parameter int WIDTH = 11,
   parameter int PTR_W = 2,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_wr,
   input logic             host_rd,
   input logic [WIDTH-1:0] host_char,
   input logic             cmd_wr,
   input logic [5:0]       cmd_word,
   input logic [PTR_W-1:0] cfg_depth,
   input logic             rx_enabled,
   input logic             rx_flush_pulse,
   input logic             locked,
   input logic [LVL_W-1:0] level,
   input logic             overrun
);
   logic [LVL_W-1:0] depth_v;
   assign depth_v = LVL_W'(cfg_depth) + 1'b1;

   p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      level <= depth_v);

   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_word[3] |=> level == '0 && !overrun);

   p_engflush_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_word[2] |=> !locked && rx_flush_pulse);

   p_unlock_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_word[5] |=> !locked);

   p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !(cmd_wr && cmd_word[3]) |=> overrun);

   p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && level == '0 |=> $stable(host_char));

   p_locked_no_growth_r7: assert property (@(posedge clk) disable iff (!rst_n)
      locked && $stable(cfg_depth) |=> level <= $past(level) || !$stable(cfg_depth));

   p_off_no_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enabled && !overrun |=> !overrun);

   p_host_rd_ignored_unused: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr && !rx_enabled && !(cmd_wr) && $stable(cfg_depth) |=> level <= $past(level) || host_rd);
endmodule

bind rxq_top rxq_top_chk #(.WIDTH(WIDTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_wr          (rx_wr),
   .host_rd        (host_rd),
   .host_char      (host_char),
   .cmd_wr         (cmd_wr),
   .cmd_word       (cmd_word),
   .cfg_depth      (cfg_depth),
   .rx_enabled     (rx_enabled),
   .rx_flush_pulse (rx_flush_pulse),
   .locked         (locked),
   .level          (level),
   .overrun        (overrun)
);

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   localparam logic [5:0] C_ON  = 6'b000001;
   localparam logic [5:0] C_OFF = 6'b000010;
   localparam logic [5:0] C_ENG = 6'b000100;
   localparam logic [5:0] C_FQ  = 6'b001000;
   localparam logic [5:0] C_LK  = 6'b010000;
   localparam logic [5:0] C_UL  = 6'b100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_wr = 1'b0;
   logic [10:0] rx_char = '0;
   logic        host_rd = 1'b0;
   logic [10:0] host_char;
   logic        cmd_wr = 1'b0;
   logic [5:0]  cmd_word = '0;
   logic [1:0]  cfg_depth = 2'd3;
   logic [1:0]  cfg_thresh = 2'd1;
   logic        rx_enabled, rx_flush_pulse, locked, full, empty, thresh_hit, overrun;
   logic [2:0]  level;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // reference state
   int          q[$];
   bit          m_en = 0, m_lk = 0, m_ovr = 0, m_pulse = 0;
   logic [10:0] m_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxq_top dut (
      .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_char(rx_char),
      .host_rd(host_rd), .host_char(host_char), .cmd_wr(cmd_wr),
      .cmd_word(cmd_word), .cfg_depth(cfg_depth), .cfg_thresh(cfg_thresh),
      .rx_enabled(rx_enabled), .rx_flush_pulse(rx_flush_pulse),
      .locked(locked), .level(level), .full(full), .empty(empty),
      .thresh_hit(thresh_hit), .overrun(overrun)
   );

   function automatic int m_level();
      int d = int'(cfg_depth) + 1;
      return (q.size() > d) ? d : q.size();
   endfunction

   task automatic compare(input string tag);
      int lv = m_level();
      int d  = int'(cfg_depth) + 1;
      bit e_full = (lv == d);
      bit e_thr  = (lv >= int'(cfg_thresh) + 1);
      checks++;
      if (int'(level) != lv || full != e_full || empty != (lv == 0) ||
          thresh_hit != e_thr || locked != m_lk || rx_enabled != m_en ||
          overrun != m_ovr || rx_flush_pulse != m_pulse || host_char !== m_rd) begin
         errors++;
         $display("FAIL %s: got lvl=%0d full=%0d emp=%0d thr=%0d lk=%0d en=%0d ovr=%0d pls=%0d data=%h; exp lvl=%0d full=%0d emp=%0d thr=%0d lk=%0d en=%0d ovr=%0d pls=%0d data=%h",
                  tag, level, full, empty, thresh_hit, locked, rx_enabled, overrun,
                  rx_flush_pulse, host_char, lv, e_full, lv == 0, e_thr, m_lk, m_en,
                  m_ovr, m_pulse, m_rd);
      end
   endtask

   task automatic step(input bit w, input logic [10:0] wd, input bit r,
                       input bit cw, input logic [5:0] c, input string tag);
      bit ff, fe, pop, acc, oset, isfull;
      @(negedge clk);
      rx_wr = w; rx_char = wd; host_rd = r; cmd_wr = cw; cmd_word = c;
      @(posedge clk);
      #1;
      ff     = cw && c[3];
      fe     = cw && c[2];
      isfull = (q.size() >= int'(cfg_depth) + 1);
      pop    = r && q.size() > 0 && !ff;
      acc    = w && m_en && !m_lk && !ff && (!isfull || pop);
      oset   = w && m_en && !ff && (m_lk || (isfull && !pop));
      if (pop) m_rd = 11'(q.pop_front());
      if (ff) begin q.delete(); m_ovr = 0; end
      else if (oset) m_ovr = 1;
      if (acc) q.push_back(int'(wd));
      if (cw) begin
         if (c[5] || c[2]) m_lk = 0;
         else if (c[4]) m_lk = 1;
         if (c[1]) m_en = 0;
         else if (c[0]) m_en = 1;
      end
      m_pulse = fe;
      rx_wr = 0; host_rd = 0; cmd_wr = 0;
      compare(tag);
   endtask

   task automatic wr(input logic [10:0] d, input string tag);
      step(1, d, 0, 0, '0, tag);
   endtask
   task automatic rd(input string tag);
      step(0, '0, 1, 0, '0, tag);
   endtask
   task automatic cmd(input logic [5:0] c, input string tag);
      step(0, '0, 0, 1, c, tag);
   endtask

   initial begin
      while (!done && cycles < WD_CYCLES) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare("R1 reset");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      compare("R1 after release");

      // R11: write while off is dropped, no overrun
      wr(11'h155, "R11 write while off");
      cmd(C_ON | C_OFF, "R11 off wins");
      cmd(C_ON, "R11 turn on");

      // R2/R6: in-order storage, threshold at two entries
      wr(11'h101, "R2 w1");
      wr(11'h0a2, "R6 w2 thresh");
      wr(11'h7f3, "R2 w3");
      rd("R2 r1"); rd("R2 r2"); rd("R6 r3");

      // R3: full, overrun, simultaneous pop and push at full
      for (int i = 0; i < 4; i++) wr(11'(16 + i), "R3 fill");
      wr(11'h3ff, "R3 write at full");
      step(1, 11'h2aa, 1, 0, '0, "R3 pop+push at full");
      wr(11'h111, "R3 overrun sticky");
      for (int i = 0; i < 4; i++) rd("R3 drain");

      // R4: read from empty
      rd("R4 empty read");
      rd("R4 empty read again");

      // R10: flush with write and read in same cycle
      wr(11'h045, "R10 pre");
      step(1, 11'h046, 1, 1, C_FQ, "R10 flush vs write+read");
      rd("R10 empty after flush");

      // R5: depth one
      cfg_depth = 2'd0; cfg_thresh = 2'd0;
      wr(11'h0c1, "R5 depth1 fill");
      wr(11'h0c2, "R5 depth1 overflow");
      rd("R5 depth1 read");
      cmd(C_FQ, "R10 clear overrun");
      cfg_depth = 2'd2; cfg_thresh = 2'd2;
      for (int i = 0; i < 4; i++) wr(11'(32 + i), "R5 depth3 fill");
      cmd(C_FQ, "R5 flush");
      cfg_depth = 2'd3; cfg_thresh = 2'd1;

      // R7/R8: lock drops writes, reads drain, pointers untouched
      wr(11'h201, "R8 pre-lock a");
      wr(11'h202, "R8 pre-lock b");
      cmd(C_LK, "R7 lock");
      wr(11'h203, "R7 write while locked");
      rd("R7 drain while locked");
      cmd(C_UL, "R8 unlock");
      wr(11'h204, "R8 post-unlock");
      rd("R8 order b"); rd("R8 order post");
      cmd(C_FQ, "R10 clear");

      // R9: engine flush wins over lock
      cmd(C_LK | C_ENG, "R9 flush engine vs lock");
      step(0, '0, 0, 0, '0, "R9 pulse ends");
      cmd(C_LK, "R12 lock");
      cmd(C_LK | C_UL, "R12 unlock wins");
      wr(11'h305, "R12 write accepted");
      rd("R12 read back");

      // mixed stream
      for (int i = 0; i < 60; i++)
         step((i % 3) != 2, 11'(i * 37), (i % 4) == 1, (i % 17) == 9,
              ((i % 34) == 9) ? C_LK : C_UL, "R2 stream");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule